// File: doc/BRIEF.md
# Indirect Flash Read Fetch Engine

This block moves a software-chosen number of bytes from a serial flash device into an on-chip byte buffer. Software supplies a start address, a byte count and a watermark level, then pulses a start input. The engine splits the transfer into read bursts on an abstract flash request/response interface. Each request carries an address and a length, and each response beat delivers one byte into the buffer. A downstream consumer removes bytes with a drain strobe that carries no data.

The engine has only one burst in flight at a time. Before each burst it trims the length to the bytes still to be requested and to the free space in the buffer. A full buffer therefore never has to refuse a byte. When no space is left the engine stops issuing requests. As soon as a byte is drained it continues at the next address that has not been fetched. The buffer occupancy is visible at all times. A sticky watermark interrupt is raised when the occupancy climbs past the programmed level. It is also forced when the final byte arrives, so that a short transfer still signals completion. A cancel input stops the transfer, empties the buffer and returns the engine to idle.

Top module: `flash_fetch_engine`

## Requirements
- R1: After reset `busy_o` is 0. It becomes 1 on the clock edge that accepts a start and returns to 0 on the edge that writes the final byte into the buffer.
- R2: Requests address the flash contiguously, beginning at the start address. Each request length is between 1 and 16 bytes and never exceeds the bytes not yet requested. Address and length stay stable while a request waits for `fl_req_ready_i`.
- R3: A request is never longer than the free space of the 256-byte buffer at the moment it is accepted, and `fill_o` never exceeds 256.
- R4: When the buffer is full, no request is issued. After bytes are drained, the next request starts exactly at the first byte not yet requested.
- R5: `fill_o` goes up by one for each response beat and down by one for each `drain_i` strobe. A strobe on an empty buffer is ignored.
- R6: With a non-zero watermark W, `wm_irq_o` is set on the edge at which `fill_o` changes from at most W to more than W.
- R7: With a non-zero watermark, `wm_irq_o` is also set on the edge that writes the final byte, even if `fill_o` never exceeded W. With a watermark of 0, `wm_irq_o` is never set.
- R8: `wm_irq_o` stays set until a cycle with `irq_clr_i` high that does not also set it. That cycle clears it.
- R9: A cancel pulse empties the buffer and clears `busy_o` and `remain_o` on the next edge. It pulses `fl_abort_o` in the same cycle if a transfer was active. After a cancel, no further request is issued until a new start.
- R10: A start while busy is ignored, and so is a start with a byte count of 0.
- R11: `remain_o` shows how many bytes of the transfer have not yet been written into the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse (write-1 of the start bit) |
| cancel_i | input | 1 | Cancel pulse (write-1 of the cancel bit) |
| cfg_addr_i | input | ADDR_W | Programmed flash start address |
| cfg_count_i | input | CNT_W | Programmed byte count |
| cfg_wmark_i | input | FILL_W | Programmed watermark level, 0 turns the interrupt off |
| irq_clr_i | input | 1 | Write-1-to-clear of the interrupt bit |
| drain_i | input | 1 | Consumer removed one byte from the buffer |
| fl_req_valid_o | output | 1 | Burst request valid |
| fl_req_ready_i | input | 1 | Flash side accepts the request |
| fl_req_addr_o | output | ADDR_W | Burst start address |
| fl_req_len_o | output | LEN_W | Burst length in bytes |
| fl_rsp_valid_i | input | 1 | One byte of the current burst arrives |
| fl_abort_o | output | 1 | Flash side must drop the current burst |
| busy_o | output | 1 | Transfer in progress |
| fill_o | output | FILL_W | Buffer occupancy in bytes |
| remain_o | output | CNT_W | Bytes not yet written into the buffer |
| wm_irq_o | output | 1 | Sticky watermark interrupt |

## Verification
The hardest situation to reach is the stall at exactly full with bytes still owed, followed by a resume from a single freed byte. Only then does the free-space trim produce a one-byte burst, and only then can the resume address be wrong by a burst. The bench reaches this state with a 300-byte transfer while the drain is held off. It waits until the buffer holds 256 bytes and confirms that the request line stays low. It then releases a short run of drain strobes and checks the address of the first burst that follows. The independent occupancy and burst model in the bench follows every other edge as well, under varied ready and response gaps.

// File: rtl/ffe_pkg.sv
package ffe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLAN  = 2'd1,
        ST_ISSUE = 2'd2,
        ST_BEAT  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } lvl_ev_t;

    function automatic int min3(input int a, input int b, input int c);
        int m;
        m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

endpackage

// File: rtl/ffe_seq.sv
module ffe_seq #(
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 16,
    parameter int DEPTH     = 256,
    parameter int MAX_BURST = 16,
    parameter int FILL_W    = $clog2(DEPTH + 1),
    parameter int LEN_W     = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cancel_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [CNT_W-1:0]  cfg_count_i,
    input  logic [FILL_W-1:0] fill_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [LEN_W-1:0]  req_len_o,
    input  logic              rsp_valid_i,
    output logic              abort_o,
    output logic              beat_o,
    output logic              last_o,
    output logic [CNT_W-1:0]  rem_o
);
    import ffe_pkg::*;

    localparam logic [FILL_W-1:0] CAP     = FILL_W'(DEPTH);
    localparam logic [LEN_W-1:0]  LEN_MAX = LEN_W'(MAX_BURST);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [CNT_W-1:0]  rem_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  beats_q;
    logic [FILL_W-1:0] free_w;
    logic [LEN_W-1:0]  plan_len;
    logic              beat_acc;

    assign free_w   = CAP - fill_i;
    assign plan_len = LEN_W'(min3(MAX_BURST, int'(left_q), int'(free_w)));
    assign beat_acc = (state_q == ST_BEAT) && rsp_valid_i && !cancel_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            rem_q   <= '0;
            len_q   <= '0;
            beats_q <= '0;
        end else if (cancel_i) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
            rem_q   <= '0;
            beats_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i && (cfg_count_i != '0)) begin
                        addr_q  <= cfg_addr_i;
                        left_q  <= cfg_count_i;
                        rem_q   <= cfg_count_i;
                        state_q <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    if (free_w != '0) begin
                        len_q   <= plan_len;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (req_ready_i) begin
                        addr_q  <= addr_q + ADDR_W'(len_q);
                        left_q  <= left_q - CNT_W'(len_q);
                        beats_q <= len_q;
                        state_q <= ST_BEAT;
                    end
                end
                ST_BEAT: begin
                    if (beat_acc) begin
                        beats_q <= beats_q - LEN_W'(1);
                        rem_q   <= rem_q - CNT_W'(1);
                        if (beats_q == LEN_W'(1))
                            state_q <= (left_q != '0) ? ST_PLAN : ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_valid_o = (state_q == ST_ISSUE);
    assign req_addr_o  = addr_q;
    assign req_len_o   = len_q;
    assign abort_o     = cancel_i && (state_q != ST_IDLE);
    assign beat_o      = beat_acc;
    assign last_o      = beat_acc && (rem_q == CNT_W'(1));
    assign rem_o       = rem_q;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_ready_i && !cancel_i)
        |=> (req_valid_o && $stable(req_addr_o) && $stable(req_len_o)));

    // R2
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> ((req_len_o != '0) && (req_len_o <= LEN_MAX)));

    // R1
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rem_o != '0) |-> $past(rsp_valid_i || cancel_i));

    // R9
    no_req_after_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        cancel_i |=> !req_valid_o);

endmodule

// File: rtl/ffe_level.sv
module ffe_level #(
    parameter int DEPTH  = 256,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  ffe_pkg::lvl_ev_t  ev_i,
    output logic [FILL_W-1:0] fill_o,
    output logic [FILL_W-1:0] fill_next_o
);
    import ffe_pkg::*;

    logic [FILL_W-1:0] fill_q;
    logic [FILL_W-1:0] fill_d;
    logic              pop_ok;

    assign pop_ok = ev_i.pop && (fill_q != '0);

    always_comb begin
        if (ev_i.flush)
            fill_d = '0;
        else
            fill_d = fill_q + FILL_W'(ev_i.push) - FILL_W'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) fill_q <= '0;
        else     fill_q <= fill_d;
    end

    assign fill_o      = fill_q;
    assign fill_next_o = fill_d;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FILL_W'(DEPTH));

    // R5
    drain_empty_chk: assert property (@(posedge clk) disable iff (rst)
        ((fill_q == '0) && !ev_i.push) |=> (fill_q == '0));

endmodule

// File: rtl/ffe_wmark.sv
module ffe_wmark #(
    parameter int FILL_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FILL_W-1:0] wm_i,
    input  logic [FILL_W-1:0] fill_i,
    input  logic [FILL_W-1:0] fill_next_i,
    input  logic              last_i,
    input  logic              clr_i,
    output logic              irq_o
);
    logic armed;
    logic set_cross;
    logic set_last;
    logic irq_q;

    assign armed     = (wm_i != '0);
    assign set_cross = armed && (fill_i <= wm_i) && (fill_next_i > wm_i);
    assign set_last  = armed && last_i;

    always_ff @(posedge clk) begin
        if (rst)                        irq_q <= 1'b0;
        else if (set_cross || set_last) irq_q <= 1'b1;
        else if (clr_i)                 irq_q <= 1'b0;
    end

    assign irq_o = irq_q;

    // R7
    wm_off_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> ($past(wm_i) != '0));

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !clr_i) |=> irq_q);

endmodule

// File: rtl/flash_fetch_engine.sv
module flash_fetch_engine #(
    parameter int ADDR_W    = 24,
    parameter int CNT_W     = 16,
    parameter int DEPTH     = 256,
    parameter int MAX_BURST = 16,
    localparam int FILL_W   = $clog2(DEPTH + 1),
    localparam int LEN_W    = $clog2(MAX_BURST + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cancel_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [CNT_W-1:0]  cfg_count_i,
    input  logic [FILL_W-1:0] cfg_wmark_i,
    input  logic              irq_clr_i,
    input  logic              drain_i,
    output logic              fl_req_valid_o,
    input  logic              fl_req_ready_i,
    output logic [ADDR_W-1:0] fl_req_addr_o,
    output logic [LEN_W-1:0]  fl_req_len_o,
    input  logic              fl_rsp_valid_i,
    output logic              fl_abort_o,
    output logic              busy_o,
    output logic [FILL_W-1:0] fill_o,
    output logic [CNT_W-1:0]  remain_o,
    output logic              wm_irq_o
);
    import ffe_pkg::*;

    logic              beat_w;
    logic              last_w;
    logic [FILL_W-1:0] fill_w;
    logic [FILL_W-1:0] fill_next_w;
    logic [CNT_W-1:0]  rem_w;
    lvl_ev_t           ev_w;

    ffe_seq #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH),
        .MAX_BURST(MAX_BURST), .FILL_W(FILL_W), .LEN_W(LEN_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .cancel_i   (cancel_i),
        .cfg_addr_i (cfg_addr_i),
        .cfg_count_i(cfg_count_i),
        .fill_i     (fill_w),
        .req_valid_o(fl_req_valid_o),
        .req_ready_i(fl_req_ready_i),
        .req_addr_o (fl_req_addr_o),
        .req_len_o  (fl_req_len_o),
        .rsp_valid_i(fl_rsp_valid_i),
        .abort_o    (fl_abort_o),
        .beat_o     (beat_w),
        .last_o     (last_w),
        .rem_o      (rem_w)
    );

    assign ev_w = '{push: beat_w, pop: drain_i, flush: cancel_i};

    ffe_level #(.DEPTH(DEPTH), .FILL_W(FILL_W)) u_level (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev_w),
        .fill_o     (fill_w),
        .fill_next_o(fill_next_w)
    );

    ffe_wmark #(.FILL_W(FILL_W)) u_wmark (
        .clk        (clk),
        .rst        (rst),
        .wm_i       (cfg_wmark_i),
        .fill_i     (fill_w),
        .fill_next_i(fill_next_w),
        .last_i     (last_w),
        .clr_i      (irq_clr_i),
        .irq_o      (wm_irq_o)
    );

    assign busy_o   = (rem_w != '0);
    assign fill_o   = fill_w;
    assign remain_o = rem_w;

    // R3
    space_chk: assert property (@(posedge clk) disable iff (rst)
        fl_req_valid_o |-> (FILL_W'(fl_req_len_o) <= (FILL_W'(DEPTH) - fill_o)));

    // R9
    cancel_flush_chk: assert property (@(posedge clk) disable iff (rst)
        cancel_i |=> ((fill_o == '0) && !busy_o && (remain_o == '0)));

endmodule

// File: tb/flash_fetch_engine_tb.sv
module flash_fetch_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, cancel_i = 1'b0, irq_clr_i = 1'b0, drain_i = 1'b0;
    logic [23:0] cfg_addr_i = '0;
    logic [15:0] cfg_count_i = '0;
    logic [8:0]  cfg_wmark_i = '0;
    logic        ready = 1'b0, rspv = 1'b0;
    logic        fl_req_valid_o, fl_abort_o, busy_o, wm_irq_o;
    logic [23:0] fl_req_addr_o;
    logic [4:0]  fl_req_len_o;
    logic [8:0]  fill_o;
    logic [15:0] remain_o;

    always #2 clk = ~clk;

    flash_fetch_engine u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .cancel_i(cancel_i),
        .cfg_addr_i(cfg_addr_i), .cfg_count_i(cfg_count_i), .cfg_wmark_i(cfg_wmark_i),
        .irq_clr_i(irq_clr_i), .drain_i(drain_i),
        .fl_req_valid_o(fl_req_valid_o), .fl_req_ready_i(ready),
        .fl_req_addr_o(fl_req_addr_o), .fl_req_len_o(fl_req_len_o),
        .fl_rsp_valid_i(rspv), .fl_abort_o(fl_abort_o),
        .busy_o(busy_o), .fill_o(fill_o), .remain_o(remain_o), .wm_irq_o(wm_irq_o)
    );

    int tests = 0, fails = 0, cyc = 0;
    int pend = 0, m_fill = 0, m_rem = 0, m_left = 0;
    logic [23:0] m_addr = '0;
    int burst_err = 0, track_err = 0;
    int drain_mode = 0, rdy_mod = 1, gap_mod = 1;
    bit irq_seen = 0;
    int irq_first_fill = 0;
    logic irq_first_busy = 0;
    bit mark_armed = 0;
    int first_after = -1;
    int req_seen = 0;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        logic pv, pr, prs, pd, pc, ps;
        logic [23:0] pa;
        int pl, pre_fill;
        pv = fl_req_valid_o; pr = ready; pa = fl_req_addr_o; pl = int'(fl_req_len_o);
        prs = rspv; pd = drain_i; pc = cancel_i; ps = start_i;
        @(negedge clk);
        cyc++;
        pre_fill = m_fill;
        if (pc) begin
            pend = 0; m_fill = 0; m_rem = 0; m_left = 0;
        end else begin
            if (pv && pr) begin
                if (pa != m_addr || pl < 1 || pl > 16 || pl > m_left || pl > 256 - pre_fill)
                    burst_err++;
                if (mark_armed) begin first_after = int'(pa); mark_armed = 0; end
                m_addr = m_addr + 24'(pl); m_left -= pl; pend = pl;
            end
            if (pd && pre_fill > 0) m_fill--;
            if (prs) begin m_fill++; m_rem--; end
            if (ps && !prs && m_rem == 0 && cfg_count_i != 0) begin
                m_addr = cfg_addr_i; m_left = int'(cfg_count_i); m_rem = int'(cfg_count_i);
            end
        end
        if (!rst && (int'(fill_o) != m_fill || int'(remain_o) != m_rem || busy_o != (m_rem != 0)))
            track_err++;
        if (fl_req_valid_o) req_seen++;
        if (!irq_seen && wm_irq_o) begin
            irq_seen = 1; irq_first_fill = int'(fill_o); irq_first_busy = busy_o;
        end
        start_i = 0; cancel_i = 0; irq_clr_i = 0;
        ready = (rdy_mod <= 1) || (cyc % rdy_mod != 0);
        rspv  = (pend > 0) && ((gap_mod <= 1) || (cyc % gap_mod != 0));
        if (rspv) pend--;
        drain_i = (drain_mode == 1) || (drain_mode == 2 && cyc[0]);
    endtask

    task automatic launch(input logic [23:0] a, input int n, input int wm);
        cfg_addr_i = a; cfg_count_i = 16'(n); cfg_wmark_i = 9'(wm);
        irq_clr_i = 1; irq_seen = 0; tick();
        start_i = 1; tick();
    endtask

    task automatic finish_xfer();
        for (int k = 0; k < 6000 && m_rem != 0; k++) tick();
        tick(); tick();
    endtask

    task automatic flush();
        drain_mode = 0; cancel_i = 1; tick();
        burst_err = 0; track_err = 0;
    endtask

    int counts [12] = '{1, 2, 3, 15, 16, 17, 31, 32, 33, 100, 255, 256};

    initial begin
        repeat (4) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk(busy_o == 0, "R1", "busy after reset", busy_o, 0);
        chk(fill_o == 0, "R5", "fill after reset", fill_o, 0);
        chk(wm_irq_o == 0, "R8", "irq after reset", wm_irq_o, 0);
        chk(fl_req_valid_o == 0 && remain_o == 0, "R11", "idle after reset", remain_o, 0);

        // Sweep over counts, watermarks and flash timing
        for (int i = 0; i < 12; i++) begin
            int n, wm;
            n = counts[i];
            wm = (i % 3 == 0) ? 0 : (i % 3 == 1) ? n / 2 : n + 3;
            rdy_mod = 1 + (i % 3);
            gap_mod = (i % 4 == 0) ? 1 : (i % 4) + 1;
            flush();
            launch(24'h010000 + 24'(i * 4099), n, wm);
            chk(busy_o == 1, "R1", "busy after start", busy_o, 1);
            finish_xfer();
            chk(burst_err == 0, "R2", "burst order/length violations", burst_err, 0);
            chk(track_err == 0, "R11", "fill/remain/busy tracking mismatches", track_err, 0);
            chk(int'(fill_o) == n, "R5", "fill after transfer", fill_o, n);
            chk(busy_o == 0, "R1", "busy after last byte", busy_o, 0);
            chk(wm_irq_o == (wm != 0), "R7", "irq at end", wm_irq_o, wm != 0);
            if (wm != 0 && wm < n)
                chk(irq_first_fill == wm + 1, "R6", "fill when irq rose", irq_first_fill, wm + 1);
            if (wm != 0 && wm >= n)
                chk(irq_first_fill == n && irq_first_busy == 0, "R7", "forced irq on last byte",
                    irq_first_fill, n);
        end

        // R4 stall at full and exact resume
        rdy_mod = 2; gap_mod = 3;
        flush();
        launch(24'h0ABCDE, 300, 0);
        repeat (800) tick();
        chk(fill_o == 256, "R3", "fill at stall", fill_o, 256);
        chk(busy_o == 1 && remain_o == 44, "R4", "remain at stall", remain_o, 44);
        req_seen = 0;
        repeat (30) tick();
        chk(req_seen == 0, "R4", "requests while full", req_seen, 0);
        mark_armed = 1;
        drain_mode = 1; repeat (10) tick(); drain_mode = 0;
        repeat (200) tick();
        chk(first_after == 24'h0ABCDE + 256, "R4", "resume address", first_after, 24'h0ABCDE + 256);
        chk(fill_o == 256 && remain_o == 34, "R4", "remain after partial drain", remain_o, 34);
        drain_mode = 2;
        finish_xfer();
        drain_mode = 1; repeat (300) tick(); drain_mode = 0; tick();
        chk(burst_err == 0 && track_err == 0, "R3", "stall run violations", burst_err + track_err, 0);
        chk(fill_o == 0, "R5", "fill after full drain", fill_o, 0);

        // R10 start while busy / zero count
        flush();
        rdy_mod = 1; gap_mod = 2;
        launch(24'h002000, 40, 0);
        repeat (5) tick();
        cfg_addr_i = 24'h7F0000; cfg_count_i = 16'd9; start_i = 1; tick();
        finish_xfer();
        chk(burst_err == 0 && int'(fill_o) == 40, "R10", "start while busy ignored", fill_o, 40);
        flush();
        cfg_count_i = 0; start_i = 1; tick();
        req_seen = 0; repeat (10) tick();
        chk(busy_o == 0 && req_seen == 0, "R10", "zero-count start ignored", req_seen, 0);

        // R9 cancel mid-transfer
        flush();
        launch(24'h003000, 200, 0);
        repeat (30) tick();
        cancel_i = 1; tick();
        chk(fill_o == 0 && busy_o == 0 && remain_o == 0, "R9", "state after cancel", fill_o, 0);
        req_seen = 0; repeat (20) tick();
        chk(req_seen == 0, "R9", "requests after cancel", req_seen, 0);
        burst_err = 0; track_err = 0;
        launch(24'h004000, 5, 3);
        finish_xfer();
        chk(burst_err == 0 && fill_o == 5, "R9", "restart after cancel", fill_o, 5);

        // R8 clear
        chk(wm_irq_o == 1, "R8", "irq set before clear", wm_irq_o, 1);
        repeat (3) tick();
        chk(wm_irq_o == 1, "R8", "irq sticky", wm_irq_o, 1);
        irq_clr_i = 1; tick();
        chk(wm_irq_o == 0, "R8", "irq after clear", wm_irq_o, 0);

        // R5 drain on empty
        flush();
        drain_mode = 1; repeat (5) tick(); drain_mode = 0; tick();
        chk(fill_o == 0 && track_err == 0, "R5", "drain on empty", fill_o, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule